// File: doc/BRIEF.md
# PLL Lock and Clock Status Register

This block is the status side of a clock module. While reset is held it captures three configuration straps: whether the system runs from the PLL, whether the PLL multiplies normally or runs 1:1, and whether the PLL reference is a crystal. After reset these bits are held. Software reads them back together with a live lock bit, a sticky lock bit and a loss-of-clock flag through a small register bus.

The live lock bit follows a lock-detect input that has passed through a two-stage synchronizer. The sticky lock bit drops on any fall of the live bit and stays low after the PLL relocks. It is set again only by a qualifying event: a write that alters the 3-bit multiplier field of the control register, or the rising edge of the frequency-modulation enable. The qualifying event may come before or after the relock; the sticky bit sets once the PLL is locked. The loss-of-clock flag is a write-one-to-clear interrupt source. The live lock value is also exported as a release condition for power-on reset.

Top module: `pll_lock_status`

## Requirements
- R1: While rst_n is low the straps are captured into status bits 7 (PLL on), 6 (normal multiply, forced to 0 when bit 7 is 0) and 5 (crystal reference, forced to 0 when bit 6 is 0). After reset these bits do not follow the straps.
- R2: Status bit 3 (live lock) and lock_por both equal lock_det delayed by two clocks, and are 0 when bit 7 is 0.
- R3: When reset is released, status bit 4 (sticky lock) is 1 if bit 7 is 1 and is 0 if bit 7 is 0. In external clock mode it stays 0 at all times.
- R4: The sticky bit clears on the clock after the live lock bit falls. A relock on its own does not set it again.
- R5: A write to the control register (reg_sel=1) whose bits [2:0] differ from the stored multiplier sets the sticky bit while the PLL is locked. A write of the same value does not set it.
- R6: A 0-to-1 change of fm_en sets the sticky bit. If the change occurs while the PLL is unlocked, the sticky bit sets when lock returns.
- R7: A high loc_evt, after two synchronizer clocks, sets status bit 2 and irq. The flag stays set after loc_evt returns low.
- R8: Writing status (reg_sel=0) with bit 2 = 1 clears the flag. Writing bit 2 = 0 has no effect. If the flag is cleared in the same cycle that a synchronized event is present, the event wins.
- R9: Status bits 1:0 and control bits 7:3 read 0. Status bits other than bit 2 ignore writes. rdata is 0 when rd_en is low.
- R10: The control register reads back its multiplier in bits [2:0] (reset value 4). mult_chg pulses for one clock right after each changing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read enable; rdata valid in the same cycle |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| reg_sel | input | 1 | 0 selects status, 1 selects control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| strap_pll_on | input | 1 | Strap: system clock from PLL |
| strap_normal | input | 1 | Strap: normal multiply mode (else 1:1) |
| strap_xtal | input | 1 | Strap: crystal reference |
| lock_det | input | 1 | Asynchronous lock-detect level |
| loc_evt | input | 1 | Asynchronous loss-of-clock level |
| fm_en | input | 1 | Frequency-modulation enable (synchronous) |
| mult_chg | output | 1 | One-clock pulse after a multiplier-changing write |
| irq | output | 1 | Loss-of-clock interrupt request |
| lock_por | output | 1 | Live lock for power-on reset release |

## Verification
The assertions assume that reset is held for at least two clocks, so that the strap synchronizer is filled before capture. They also assume that fm_en is already synchronous to clk. The stimulus holds reset for five clocks. It changes lock_det, loc_evt and the straps only between edges and then waits long enough for the two-stage synchronizer before reading. A sweep covers all eight strap combinations with lock both high and low, and directed sequences cover each way of losing and re-arming the sticky bit.

// File: rtl/clkstat_pkg.sv
// Shared field positions and types of the PLL status register.
// Assumes an 8-bit data path; bit positions are fixed by the register layout.
package clkstat_pkg;
    localparam int DATA_W    = 8;
    localparam int BIT_PLLON = 7;
    localparam int BIT_NORM  = 6;
    localparam int BIT_XTAL  = 5;
    localparam int BIT_STKY  = 4;
    localparam int BIT_LIVE  = 3;
    localparam int BIT_LOC   = 2;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CTRL   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic pll_on;
        logic normal;
        logic xtal;
    } clk_cfg_t;
endpackage

// File: rtl/cs_sync.sv
// Multi-stage synchronizer for asynchronous levels.
// No reset: the chain fills while reset is held (assumes reset >= STAGES clocks).
module cs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the asynchronous value through the flop chain.
    always_ff @(posedge clk) begin
        chain[0] <= async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/cs_lock_track.sv
// Live and sticky lock tracking.
// The live bit is the synchronized lock gated by PLL mode. The sticky bit clears
// when the live bit falls and re-sets only after a qualifying event, once locked.
// Assumes qual_evt is a single-cycle synchronous pulse.
module cs_lock_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_on_rst,
    input  logic pll_on,
    input  logic lock_sync,
    input  logic qual_evt,
    output logic live,
    output logic sticky
);
    logic live_q;
    logic pend_q;
    logic sticky_q;
    logic lost;
    logic set_now;

    assign live    = pll_on & lock_sync;
    assign lost    = live_q & ~live;
    assign set_now = (pend_q | qual_evt) & live;
    assign sticky  = sticky_q;

    // Track the previous live value, the armed event and the sticky bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q   <= 1'b0;
            pend_q   <= 1'b0;
            sticky_q <= pll_on_rst;
        end else begin
            live_q <= live;
            pend_q <= pll_on & ~set_now & (pend_q | qual_evt);
            if (lost) begin
                sticky_q <= 1'b0;
            end else if (set_now) begin
                sticky_q <= 1'b1;
            end
        end
    end

    p_ext_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |-> !sticky_q);
    p_loss_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(live) |=> !sticky_q);
    p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_q && !qual_evt && !pend_q) |=> !sticky_q);
    p_set_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_q ##1 sticky_q) |-> $past(live));
endmodule

// File: rtl/cs_loc_flag.sv
// Loss-of-clock flag, write-one-to-clear, sticky while no clear arrives.
// Assumes evt is already synchronized; an event beats a clear in the same cycle.
module cs_loc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr_req,
    output logic flag
);
    // Set on event, clear on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (evt) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr_req && !evt) |=> !flag);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
endmodule

// File: rtl/pll_lock_status.sv
// PLL status and sticky lock register top.
// Captures configuration straps during reset, synchronizes lock and
// loss-of-clock levels, and holds the multiplier control field whose changes
// qualify a new sticky lock. Assumes fm_en is synchronous to clk.
module pll_lock_status #(
    parameter int               MULT_W     = 3,
    parameter int               SYNC_STG   = 2,
    parameter logic [MULT_W-1:0] MULT_RESET = 3'd4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic                        wr_en,
    input  logic                        reg_sel,
    input  logic [clkstat_pkg::DATA_W-1:0] wdata,
    output logic [clkstat_pkg::DATA_W-1:0] rdata,
    input  logic                        strap_pll_on,
    input  logic                        strap_normal,
    input  logic                        strap_xtal,
    input  logic                        lock_det,
    input  logic                        loc_evt,
    input  logic                        fm_en,
    output logic                        mult_chg,
    output logic                        irq,
    output logic                        lock_por
);
    import clkstat_pkg::*;

    localparam int SYNC_W = 5;
    localparam int PAD_W  = DATA_W - MULT_W;

    logic [SYNC_W-1:0] sync_q;
    clk_cfg_t          strap_s;
    clk_cfg_t          cfg_q;
    logic              lock_s;
    logic              loc_s;
    logic [MULT_W-1:0] mult_q;
    logic              mult_chg_q;
    logic              fm_q;
    logic              wr_ctrl;
    logic              wr_stat;
    logic              mult_diff;
    logic              qual_evt;
    logic              live;
    logic              sticky;
    logic              loc_flag;
    logic              unused_wbits;

    cs_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STG)) sync_i (
        .clk    (clk),
        .async_i({strap_pll_on, strap_normal, strap_xtal, lock_det, loc_evt}),
        .sync_o (sync_q)
    );

    assign strap_s.pll_on = sync_q[4];
    assign strap_s.normal = sync_q[4] & sync_q[3];
    assign strap_s.xtal   = sync_q[4] & sync_q[3] & sync_q[2];
    assign lock_s         = sync_q[1];
    assign loc_s          = sync_q[0];

    assign wr_ctrl   = wr_en & (reg_sel_e'(reg_sel) == SEL_CTRL);
    assign wr_stat   = wr_en & (reg_sel_e'(reg_sel) == SEL_STATUS);
    assign mult_diff = wr_ctrl & (wdata[MULT_W-1:0] != mult_q);
    assign qual_evt  = mult_diff | (fm_en & ~fm_q);
    assign unused_wbits = ^wdata[DATA_W-1:MULT_W];

    // Capture the straps while reset is held, then hold them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= strap_s;
        end
    end

    // Multiplier field, its change pulse and the modulation-enable history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q     <= MULT_RESET;
            mult_chg_q <= 1'b0;
            fm_q       <= 1'b0;
        end else begin
            mult_chg_q <= mult_diff;
            fm_q       <= fm_en;
            if (wr_ctrl) begin
                mult_q <= wdata[MULT_W-1:0];
            end
        end
    end

    cs_lock_track lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pll_on_rst(strap_s.pll_on),
        .pll_on    (cfg_q.pll_on),
        .lock_sync (lock_s),
        .qual_evt  (qual_evt),
        .live      (live),
        .sticky    (sticky)
    );

    cs_loc_flag loc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (loc_s),
        .clr_req(wr_stat & wdata[BIT_LOC]),
        .flag   (loc_flag)
    );

    // Read multiplexer: zero when idle, status or control image otherwise.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (reg_sel_e'(reg_sel) == SEL_CTRL) begin
                rdata = {{PAD_W{1'b0}}, mult_q};
            end else begin
                rdata[BIT_PLLON] = cfg_q.pll_on;
                rdata[BIT_NORM]  = cfg_q.normal;
                rdata[BIT_XTAL]  = cfg_q.xtal;
                rdata[BIT_STKY]  = sticky;
                rdata[BIT_LIVE]  = live;
                rdata[BIT_LOC]   = loc_flag;
            end
        end
    end

    assign mult_chg = mult_chg_q;
    assign irq      = loc_flag;
    assign lock_por = live;

    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));
    p_mode_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((!cfg_q.normal || cfg_q.pll_on) && (!cfg_q.xtal || cfg_q.normal)));
    p_mchg_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mult_chg |-> $past(wr_en && reg_sel));
    p_por_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_por |-> cfg_q.pll_on);
endmodule

// File: tb/pll_lock_status_tb_top.sv
// Self-checking bench: strap/lock sweep plus directed sticky and flag sequences.
module pll_lock_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0, reg_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       strap_pll_on = 1'b0, strap_normal = 1'b0, strap_xtal = 1'b0;
    logic       lock_det = 1'b0, loc_evt = 1'b0, fm_en = 1'b0;
    logic       mult_chg, irq, lock_por;
    int         n_chk = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    pll_lock_status dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .strap_pll_on(strap_pll_on),
        .strap_normal(strap_normal), .strap_xtal(strap_xtal), .lock_det(lock_det),
        .loc_evt(loc_evt), .fm_en(fm_en), .mult_chg(mult_chg), .irq(irq),
        .lock_por(lock_por)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_en = 1'b1;
        reg_sel = sel;
        #2;
        v = rdata;
        cyc(1);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1;
        reg_sel = sel;
        wdata = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic [2:0] s, input logic lk);
        {strap_pll_on, strap_normal, strap_xtal} = s;
        lock_det = lk;
        rst_n = 1'b0;
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
    endtask

    function automatic logic [7:0] stat(input logic [2:0] s, input logic sk,
                                        input logic lv, input logic lc);
        logic m, n, x;
        m = s[2];
        n = s[1] & m;
        x = s[0] & n;
        return {m, n, x, sk, lv, lc, 2'b00};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        cyc(1);
        // R1 R2 R3: sweep all strap settings with lock high and low
        for (int s = 0; s < 8; s++) begin
            for (int lk = 0; lk < 2; lk++) begin
                do_reset(s[2:0], lk[0]);
                rd(1'b0, v);
                chk("R1/R3 status after reset", v,
                    stat(s[2:0], s[2], s[2] & lk[0], 1'b0));
                chk("R2 lock_por", {7'd0, lock_por}, {7'd0, s[2] & lk[0]});
            end
        end

        // Normal PLL mode, external reference, locked
        do_reset(3'b110, 1'b1);
        rd(1'b1, v);
        chk("R10 control reset value", v, 8'h04);
        // R1: strap changes after reset are not seen
        {strap_pll_on, strap_normal, strap_xtal} = 3'b001;
        cyc(4);
        rd(1'b0, v);
        chk("R1 straps held", v, stat(3'b110, 1'b1, 1'b1, 1'b0));

        // R4: loss clears sticky, relock alone does not set it
        lock_det = 1'b0;
        cyc(5);
        rd(1'b0, v);
        chk("R4 loss clears sticky", v, stat(3'b110, 1'b0, 1'b0, 1'b0));
        chk("R2 lock_por low", {7'd0, lock_por}, 8'h00);
        lock_det = 1'b1;
        cyc(5);
        rd(1'b0, v);
        chk("R4 relock keeps sticky low", v, stat(3'b110, 1'b0, 1'b1, 1'b0));

        // R5: same-value write does not qualify
        wr(1'b1, 8'h04);
        chk("R10 no pulse on same value", {7'd0, mult_chg}, 8'h00);
        rd(1'b0, v);
        chk("R5 same value no set", v, stat(3'b110, 1'b0, 1'b1, 1'b0));
        // R5 R10: changing write qualifies
        wr(1'b1, 8'h05);
        chk("R10 pulse after change", {7'd0, mult_chg}, 8'h01);
        rd(1'b0, v);
        chk("R5 change sets sticky", v, stat(3'b110, 1'b1, 1'b1, 1'b0));
        chk("R10 pulse one clock", {7'd0, mult_chg}, 8'h00);
        rd(1'b1, v);
        chk("R10 control readback", v, 8'h05);

        // R6: modulation enable rising edge while locked
        lock_det = 1'b0;
        cyc(5);
        lock_det = 1'b1;
        cyc(5);
        fm_en = 1'b1;
        cyc(1);
        rd(1'b0, v);
        chk("R6 fm rise sets sticky", v, stat(3'b110, 1'b1, 1'b1, 1'b0));
        fm_en = 1'b0;
        // R6: event while unlocked, sets on relock
        lock_det = 1'b0;
        cyc(5);
        fm_en = 1'b1;
        cyc(1);
        fm_en = 1'b0;
        rd(1'b0, v);
        chk("R6 armed while unlocked", v, stat(3'b110, 1'b0, 1'b0, 1'b0));
        lock_det = 1'b1;
        cyc(5);
        rd(1'b0, v);
        chk("R6 set on relock", v, stat(3'b110, 1'b1, 1'b1, 1'b0));

        // R7 R8: loss-of-clock flag
        loc_evt = 1'b1;
        cyc(4);
        loc_evt = 1'b0;
        cyc(4);
        chk("R7 irq sticky", {7'd0, irq}, 8'h01);
        wr(1'b0, 8'hFB);
        rd(1'b0, v);
        chk("R8 write 0 no effect, R9 ro bits", v, stat(3'b110, 1'b1, 1'b1, 1'b1));
        wr(1'b0, 8'h04);
        chk("R8 w1c clears", {7'd0, irq}, 8'h00);
        loc_evt = 1'b1;
        cyc(4);
        wr(1'b0, 8'h04);
        chk("R8 event wins", {7'd0, irq}, 8'h01);
        loc_evt = 1'b0;
        cyc(4);
        wr(1'b0, 8'hFF);
        rd(1'b0, v);
        chk("R8 clear after event, R9", v, stat(3'b110, 1'b1, 1'b1, 1'b0));

        // R9: control upper bits and idle read
        wr(1'b1, 8'hFF);
        rd(1'b1, v);
        chk("R9 control upper bits zero", v, 8'h07);
        reg_sel = 1'b0;
        #2;
        chk("R9 idle rdata zero", rdata, 8'h00);
        cyc(1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule